// File: doc/BRIEF.md
# Shared Interrupt Trigger Unit

This block takes a bank of external interrupt lines shared by the whole chip and turns each one into a pending flag. Every source can be set to level or edge sensing. It has a polarity bit, and an edge source can also be set to react to both edges. Software can also force or withdraw the pending flag of a single edge source through an injection register. Each source carries an enable bit. That bit is set through a write-one set bank and cleared through a write-one clear bank. Pending and enabled sources are then routed to a numbered processor request pin or to a non-maskable request output.

All configuration and status is reached through a plain 32-bit register port. A write takes effect on the clock edge where `reg_wr` is high. A read is requested with `reg_rd`, and its data appears on `reg_rdata` one cycle later. Per-source bank bits are packed one bit per source: bit n of the word at the bank offset (plus 4 per further group of 32 sources) belongs to source n. The request outputs are registered.

Top module: `irq_trigger_hub`

## Requirements
- R1: After reset the polarity, sense, both-edge, enable and routing registers all read 0, and `cpu_irq` and `nmi_irq` are low.
- R2: The polarity bank (0x100), sense bank (0x180) and both-edge bank (0x200) read back what was written. Read data is valid the cycle after `reg_rd`. Any offset with no register, including the injection register at 0x280, reads 0.
- R3: With sense bit 0 (level), a source is pending while its input, after a two-flop synchronizer, equals its polarity bit (1 = active high, 0 = active low). The flag follows the input with no latching.
- R4: With sense bit 1 (edge) and both-edge bit 0, a rising input edge sets the pending latch when polarity is 1, and a falling edge sets it when polarity is 0. The latch then holds after the input returns.
- R5: With sense bit 1 and both-edge bit 1, either edge sets the pending latch, whatever the polarity bit.
- R6: A write to 0x280 selects the source in bits 7:0. With bit 31 = 1 it sets that source's pending latch, and with bit 31 = 0 it clears it. An edge event in the same cycle as a clear wins. An index at or above the source count changes nothing.
- R7: Writing 1s to 0x380 enables those sources and writing 1s to 0x300 disables them. Bits written as 0 leave the enables unchanged. The enables read at 0x400 and the pending flags read at 0x480. Writes to those two offsets are ignored.
- R8: Source n has a routing register at 0x500 + 4n. Bit 31 routes the source to the pin numbered in bits 5:0, and bit 30 routes it to the non-maskable output instead, taking precedence over bit 31. Only bits 31, 30 and 5:0 are stored; all other bits read 0.
- R9: Each cycle, `cpu_irq[p]` registers the OR of sources that are pending, enabled, pin-routed (bit 31 set, bit 30 clear) and numbered p. `nmi_irq` registers the OR of sources that are pending, enabled and have bit 30 set. A pin number at or above the pin count drives nothing, and a disabled source drives nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_SRC | Asynchronous external interrupt lines |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| cpu_irq | output | NUM_PINS | Per-pin processor request lines |
| nmi_irq | output | 1 | Non-maskable request line |

## Verification
The hardest case to reach is an injected clear that lands in the same clock edge as a real edge event on the same source. To hit it, the stimulus changes the input on a falling clock edge and counts the two synchronizer stages. It then issues the clear write so that it is sampled on exactly the edge where the detector fires, and expects the flag to survive. Around that, the bench sweeps every source through several polarity, sense and both-edge patterns and several input transitions. It computes the pending vector and the pin image arithmetically from the written configuration.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;

  localparam int OFS_POL   = 'h100;
  localparam int OFS_SENSE = 'h180;
  localparam int OFS_BOTH  = 'h200;
  localparam int OFS_INJ   = 'h280;
  localparam int OFS_DIS   = 'h300;
  localparam int OFS_EN    = 'h380;
  localparam int OFS_ENRD  = 'h400;
  localparam int OFS_PEND  = 'h480;
  localparam int OFS_ROUTE = 'h500;

  typedef struct packed {
    logic       pin_en;
    logic       nmi_en;
    logic [5:0] pin;
  } irq_route_t;

  function automatic logic [31:0] route_word(input irq_route_t r);
    return {r.pin_en, r.nmi_en, 24'd0, r.pin};
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
      q       <= '0;
    end else begin
      stage_q <= d;
      q       <= stage_q;
    end
  end
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  input  logic cfg_edge,
  input  logic cfg_pol,
  input  logic cfg_dual,
  input  logic inj_set,
  input  logic inj_clr,
  output logic pend
);
  logic prev_q, latch_q, rise, fall, evt;

  assign rise = level_in & ~prev_q;
  assign fall = ~level_in & prev_q;
  assign evt  = cfg_edge & (cfg_dual ? (rise | fall) : (cfg_pol ? rise : fall));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q <= level_in;
      if (evt || inj_set)  latch_q <= 1'b1;
      else if (inj_clr)    latch_q <= 1'b0;
    end
  end

  assign pend = cfg_edge ? latch_q : ~(level_in ^ cfg_pol);

  // R6: a clear with no competing set empties the latch
  p_inj_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_clr && !inj_set && !evt) |=> !latch_q);
  // R6: a detected edge always leaves the latch set, even against a clear
  p_event_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> latch_q);
  // R4: a set latch holds until an explicit clear
  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && !inj_clr) |=> latch_q);
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_trig_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  active,
  input  irq_route_t          routes [NUM_SRC],
  output logic [NUM_PINS-1:0] pin_q,
  output logic                nmi_q
);
  logic [NUM_PINS-1:0] pin_d;
  logic                nmi_d;

  always_comb begin
    pin_d = '0;
    nmi_d = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (active[i]) begin
        if (routes[i].nmi_en) begin
          nmi_d = 1'b1;
        end else if (routes[i].pin_en) begin
          for (int p = 0; p < NUM_PINS; p++) begin
            if (int'(routes[i].pin) == p) pin_d[p] = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q <= '0;
      nmi_q <= 1'b0;
    end else begin
      pin_q <= pin_d;
      nmi_q <= nmi_d;
    end
  end

  // R9: with nothing pending and enabled, all request lines drop next cycle
  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active == '0) |=> (pin_q == '0 && !nmi_q));
endmodule

// File: rtl/irq_trigger_hub.sv
module irq_trigger_hub
  import irq_trig_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  irq_in,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic [NUM_PINS-1:0] cpu_irq,
  output logic                nmi_irq
);
  localparam int LOW_W = (NUM_SRC < 32) ? NUM_SRC : 32;

  logic [NUM_SRC-1:0] cfg_pol, cfg_sense, cfg_both, en_q;
  logic [NUM_SRC-1:0] sync_in, pend, inj_set, inj_clr;
  irq_route_t         routes_q [NUM_SRC];
  logic [31:0]        rd_d;
  logic               inj_hit;

  function automatic logic at(input logic [ADDR_W-1:0] a, input int ofs);
    return a == ADDR_W'(ofs);
  endfunction

  irq_sync #(.W(NUM_SRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_in), .q(sync_in)
  );

  assign inj_hit = reg_wr && at(reg_addr, OFS_INJ);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign inj_set[i] = inj_hit && reg_wdata[31]  && (reg_wdata[7:0] == 8'(i));
    assign inj_clr[i] = inj_hit && !reg_wdata[31] && (reg_wdata[7:0] == 8'(i));

    irq_src_cell u_cell (
      .clk(clk), .rst_n(rst_n), .level_in(sync_in[i]),
      .cfg_edge(cfg_sense[i]), .cfg_pol(cfg_pol[i]), .cfg_dual(cfg_both[i]),
      .inj_set(inj_set[i]), .inj_clr(inj_clr[i]), .pend(pend[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_pol   <= '0;
      cfg_sense <= '0;
      cfg_both  <= '0;
      en_q      <= '0;
      for (int i = 0; i < NUM_SRC; i++) routes_q[i] <= '0;
    end else if (reg_wr) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (at(reg_addr, OFS_POL   + 4 * (i / 32))) cfg_pol[i]   <= reg_wdata[i % 32];
        if (at(reg_addr, OFS_SENSE + 4 * (i / 32))) cfg_sense[i] <= reg_wdata[i % 32];
        if (at(reg_addr, OFS_BOTH  + 4 * (i / 32))) cfg_both[i]  <= reg_wdata[i % 32];
        if (at(reg_addr, OFS_EN  + 4 * (i / 32)) && reg_wdata[i % 32]) en_q[i] <= 1'b1;
        if (at(reg_addr, OFS_DIS + 4 * (i / 32)) && reg_wdata[i % 32]) en_q[i] <= 1'b0;
        if (at(reg_addr, OFS_ROUTE + 4 * i)) begin
          routes_q[i].pin_en <= reg_wdata[31];
          routes_q[i].nmi_en <= reg_wdata[30];
          routes_q[i].pin    <= reg_wdata[5:0];
        end
      end
    end
  end

  always_comb begin
    rd_d = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (at(reg_addr, OFS_POL   + 4 * (i / 32))) rd_d[i % 32] = cfg_pol[i];
      if (at(reg_addr, OFS_SENSE + 4 * (i / 32))) rd_d[i % 32] = cfg_sense[i];
      if (at(reg_addr, OFS_BOTH  + 4 * (i / 32))) rd_d[i % 32] = cfg_both[i];
      if (at(reg_addr, OFS_ENRD  + 4 * (i / 32))) rd_d[i % 32] = en_q[i];
      if (at(reg_addr, OFS_PEND  + 4 * (i / 32))) rd_d[i % 32] = pend[i];
      if (at(reg_addr, OFS_ROUTE + 4 * i))        rd_d = route_word(routes_q[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_d;
  end

  irq_router #(.NUM_SRC(NUM_SRC), .NUM_PINS(NUM_PINS)) u_router (
    .clk(clk), .rst_n(rst_n), .active(pend & en_q), .routes(routes_q),
    .pin_q(cpu_irq), .nmi_q(nmi_irq)
  );

  // R7: bits written 1 to the enable-set bank are enabled afterwards
  p_en_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && at(reg_addr, OFS_EN)) |=>
      ((en_q[LOW_W-1:0] & $past(reg_wdata[LOW_W-1:0])) == $past(reg_wdata[LOW_W-1:0])));
  // R7: bits written 1 to the enable-clear bank are disabled afterwards
  p_en_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && at(reg_addr, OFS_DIS)) |=>
      ((en_q[LOW_W-1:0] & $past(reg_wdata[LOW_W-1:0])) == '0));
  // R7: the enable bank moves only on writes to its set or clear offsets
  p_en_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && (at(reg_addr, OFS_EN) || at(reg_addr, OFS_DIS))) |=> $stable(en_q));
endmodule

// File: tb/irq_trigger_hub_bench.sv
module irq_trigger_hub_bench;
  localparam int NS = 32;
  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] irq_in = '1;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NP-1:0] cpu_irq;
  logic          nmi_irq;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] m_mask;
  bit          m_pe [NS];
  bit          m_ne [NS];
  int          m_pin [NS];

  always #2 clk = ~clk;

  irq_trigger_hub u_irq_trigger_hub (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_irq(cpu_irq), .nmi_irq(nmi_irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 12'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 12'(a);
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic expect_rd(input int a, input logic [31:0] e, input string req);
    logic [31:0] v;
    rd(a, v);
    chk(v === e, req, v, e);
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic clear_all();
    for (int i = 0; i < NS; i++) wr('h280, 32'(i));
  endtask

  function automatic logic [NP-1:0] exp_pins(input logic [31:0] act);
    logic [NP-1:0] r = '0;
    for (int i = 0; i < NS; i++)
      if (act[i] && m_pe[i] && !m_ne[i] && m_pin[i] < NP) r[m_pin[i]] = 1'b1;
    return r;
  endfunction

  function automatic logic exp_nmi(input logic [31:0] act);
    logic r = 1'b0;
    for (int i = 0; i < NS; i++) if (act[i] && m_ne[i]) r = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] edges(input logic [31:0] x0, x1, pol, dual);
    return (dual & (x0 ^ x1)) | (~dual & ((pol & x1 & ~x0) | (~pol & ~x1 & x0)));
  endfunction

  task automatic check_out(input logic [31:0] pexp, input string req);
    logic [31:0] act;
    act = pexp & m_mask;
    expect_rd('h480, pexp, req);
    chk(cpu_irq === exp_pins(act), req, 32'(cpu_irq), 32'(exp_pins(act)));
    chk(nmi_irq === exp_nmi(act), req, 32'(nmi_irq), 32'(exp_nmi(act)));
  endtask

  task automatic set_route(input int s, input bit pe, input bit ne, input int pin);
    wr('h500 + 4 * s, {pe, ne, 24'hABCD00, 6'(pin)});
    m_pe[s] = pe; m_ne[s] = ne; m_pin[s] = pin;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_vec++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] pat [4];
    logic [31:0] pe;
    logic [31:0] ep [5];
    logic [31:0] ed [5];
    logic [31:0] x0s [2];
    logic [31:0] x1s [2];
    pat = '{32'h0, 32'hFFFF_FFFF, 32'h1234_5678, 32'h0F0F_F0F0};
    ep  = '{32'hFFFF_FFFF, 32'h0, 32'h5A5A_5A5A, 32'h0, 32'hC3C3_C3C3};
    ed  = '{32'h0, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h00FF_00FF};
    x0s = '{32'h0, 32'h1234_5678};
    x1s = '{32'hFFFF_FFFF, 32'h8765_4321};
    m_mask = '0;
    for (int i = 0; i < NS; i++) begin m_pe[i] = 0; m_ne[i] = 0; m_pin[i] = 0; end

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(cpu_irq === '0, "R1 pins", 32'(cpu_irq), 0);
    chk(nmi_irq === 1'b0, "R1 nmi", 32'(nmi_irq), 0);
    expect_rd('h100, 0, "R1 pol");
    expect_rd('h180, 0, "R1 sense");
    expect_rd('h200, 0, "R1 both");
    expect_rd('h400, 0, "R1 enable");
    expect_rd('h500, 0, "R1 route0");
    expect_rd('h57C, 0, "R1 route31");

    // R2: bank readback and unmapped offsets
    wr('h100, 32'hA5A5_5A5A); wr('h180, 32'h0); wr('h200, 32'h0F0F_0F0F);
    expect_rd('h100, 32'hA5A5_5A5A, "R2 pol");
    expect_rd('h200, 32'h0F0F_0F0F, "R2 both");
    wr('h200, 0);
    expect_rd('h180, 0, "R2 sense");
    foreach (pat[k]) begin end
    expect_rd('h000, 0, "R2 unmapped 000");
    expect_rd('h104, 0, "R2 unmapped 104");
    expect_rd('h280, 0, "R2 inject reads zero");
    expect_rd('h580, 0, "R2 unmapped 580");
    expect_rd('hFFC, 0, "R2 unmapped FFC");

    // R7: enable set/clear semantics
    wr('h380, 32'hFFFF_0000); expect_rd('h400, 32'hFFFF_0000, "R7 set");
    wr('h300, 32'h00FF_0000); expect_rd('h400, 32'hFF00_0000, "R7 clear");
    wr('h380, 0); wr('h300, 0); expect_rd('h400, 32'hFF00_0000, "R7 zeros ignored");
    wr('h400, 32'hFFFF_FFFF); wr('h480, 32'hFFFF_FFFF);
    expect_rd('h400, 32'hFF00_0000, "R7 readonly");
    wr('h380, 32'hFFFF_FFFF); m_mask = 32'hFFFF_FFFF;

    // R8: routing readback for every source
    for (int s = 0; s < NS; s++) begin
      set_route(s, 1, 0, s % NP);
      expect_rd('h500 + 4 * s, 32'h8000_0000 | 32'(s % NP), "R8 route readback");
    end

    // R3: level sensing sweep
    for (int pi = 0; pi < 3; pi++) begin
      logic [31:0] pol;
      pol = (pi == 0) ? 32'h0 : (pi == 1) ? 32'hFFFF_FFFF : 32'hA5A5_A5A5;
      wr('h100, pol);
      for (int xi = 0; xi < 4; xi++) begin
        irq_in = pat[xi];
        settle();
        check_out(~(pat[xi] ^ pol), "R3 level");
      end
    end

    // R9: disabled sources drive nothing
    irq_in = 32'h0; wr('h100, 32'hFFFF_FFFF); wr('h100, 32'h0);
    wr('h300, 32'hFFFF_0000); m_mask = 32'h0000_FFFF;
    settle();
    check_out(32'hFFFF_FFFF, "R9 masked");
    chk(cpu_irq === 8'hFF, "R9 low half", 32'(cpu_irq), 32'hFF);
    wr('h300, 32'h0000_FFFF); m_mask = 32'h0;
    settle();
    check_out(32'hFFFF_FFFF, "R9 all masked");
    wr('h380, 32'hFFFF_FFFF); m_mask = 32'hFFFF_FFFF;

    // R4 and R5: edge sweeps
    wr('h180, 32'hFFFF_FFFF);
    for (int c = 0; c < 5; c++) begin
      wr('h100, ep[c]); wr('h200, ed[c]);
      for (int t = 0; t < 2; t++) begin
        logic [31:0] e;
        irq_in = x0s[t]; settle(); clear_all(); settle();
        check_out(0, "R4 cleared");
        irq_in = x1s[t]; settle();
        e = edges(x0s[t], x1s[t], ep[c], ed[c]);
        check_out(e, (ed[c] != 0) ? "R5 edge" : "R4 edge");
        irq_in = x0s[t]; settle();
        e |= edges(x1s[t], x0s[t], ep[c], ed[c]);
        check_out(e, (ed[c] != 0) ? "R5 hold" : "R4 hold");
      end
    end

    // R6: injection set/clear, out-of-range index
    wr('h100, 32'hFFFF_FFFF); wr('h200, 0);
    irq_in = 0; settle(); clear_all(); settle();
    wr('h280, 32'h8000_0005); settle(); check_out(32'h0000_0020, "R6 set 5");
    wr('h280, 32'h8000_001F); settle(); check_out(32'h8000_0020, "R6 set 31");
    wr('h280, 32'h0000_0005); settle(); check_out(32'h8000_0000, "R6 clear 5");
    wr('h280, 32'h8000_00C8); settle(); check_out(32'h8000_0000, "R6 index out of range");
    clear_all(); settle();

    // R6: clear collides with a detected rising edge on source 9
    @(negedge clk); irq_in = 32'h0000_0200;
    @(negedge clk);
    wr('h280, 32'h0000_0009);
    settle(); check_out(32'h0000_0200, "R6 event beats clear");
    wr('h280, 32'h0000_0009); settle(); check_out(0, "R6 clear after event");

    // R8 and R9: non-maskable route, precedence and out-of-range pin
    set_route(3, 1, 1, 2);
    wr('h280, 32'h8000_0003); settle();
    check_out(32'h0000_0208 & 32'h0000_0008, "R8 nmi precedence");
    chk(nmi_irq === 1'b1 && cpu_irq === '0, "R8 nmi only", {nmi_irq, 23'd0, cpu_irq}, 32'h8000_0000);
    set_route(3, 1, 0, 40); settle();
    check_out(32'h0000_0008, "R9 pin out of range");
    chk(cpu_irq === '0, "R9 no pin", 32'(cpu_irq), 0);
    set_route(3, 1, 0, 7); settle();
    check_out(32'h0000_0008, "R9 pin 7");
    chk(cpu_irq === 8'h80, "R9 pin 7 line", 32'(cpu_irq), 32'h80);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule